// File: doc/BRIEF.md
# Ping-Pong Receive Buffer Manager

This block is the receive half of a small Ethernet-style MAC. It takes a frame as a byte stream, with a valid strobe and a last-byte marker. It decides from the first six bytes whether the frame is addressed to this station, and packs accepted frames into one of two receive buffers. A host reads the buffers through 32-bit word reads in a local address window. Each buffer has a 32-bit control word. Bit 0 of that word is the full flag and bit 3 is the interrupt-enable flag. Once the host has consumed a buffer, it frees the buffer by writing the control word with bit 0 clear.

Ping-pong mode lets consecutive frames land in alternate buffers, so the host can drain one buffer while the other fills. If the buffer a frame is aimed at is still full, the whole frame is discarded and a saturating lost-frame counter is bumped. An interrupt pulse follows each stored frame when the global enable input and the interrupt-enable flag of buffer 0 are both set. The buffer that received the frame makes no difference to this.

Top module: `rxpp_rx_buffers`

## Requirements
- R1: The host window is 2*BUF_BYTES bytes. Address bit ADDR_W-1 selects the buffer and bits ADDR_W-2..2 select the word. The highest word of each half is that buffer's control word and the other words are frame data. Data words are read-only, so a host write to them has no effect.
- R2: A frame is accepted when bit 0 of its first byte is 1, or when its bytes 0..5 equal station_mac (byte k compared with bits 8k+7..8k). Any other frame, and any frame shorter than 6 bytes, leaves buffer data and control words unchanged.
- R3: The target buffer's full flag (control bit 0) is sampled at the frame's first byte. If it is 1, the frame is dropped and both buffers stay unchanged. If the dropped frame would have passed the filter, lost_frames increments by one, saturating at its maximum.
- R4: Frame byte n of a stored frame is at data word n/4, bits 8*(n%4)+7..8*(n%4). The unused upper lanes of the final word read as zero.
- R5: Storing a frame sets bit 0 of the target buffer's control word and keeps its other bits.
- R6: rx_irq is high for exactly the one cycle after the last byte of a stored frame. It goes high only if bit 3 of buffer 0's control word and irq_global_en are both 1, whichever buffer received the frame.
- R7: With pingpong_en high, the target buffer alternates after every stored frame. With pingpong_en low, every frame targets buffer 0.
- R8: After reset, both control words are zero, buffer 0 is the target, lost_frames is zero and rx_irq and host_rvalid are low.
- R9: A host write to a control word stores all 32 bits as written. Writing bit 0 as zero frees the buffer for the next frame.
- R10: A frame longer than BUF_BYTES-4 bytes does not set the full flag, raises no interrupt, does not move the target buffer and is not counted as lost.
- R11: host_rvalid is high in exactly the cycle after each host_rd, and host_rdata holds the addressed word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Frame byte |
| rx_valid | input | 1 | rx_data carries a byte this cycle |
| rx_last | input | 1 | This byte ends the frame |
| station_mac | input | 48 | Station address, first wire byte in bits 7..0 |
| pingpong_en | input | 1 | Alternate between the two buffers |
| irq_global_en | input | 1 | Global interrupt enable |
| host_addr | input | ADDR_W | Byte address within the window |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Read data, one cycle after host_rd |
| host_rvalid | output | 1 | host_rdata is valid |
| rx_irq | output | 1 | Receive interrupt pulse |
| lost_frames | output | LOST_W | Saturating count of dropped frames |

## Verification
The assertions rely on three assumptions about the inputs: rx_last is raised only together with rx_valid, a frame runs from its first valid byte to its last without the stream restarting, and host_rd and host_wr are never raised in the same cycle. The bench drives frames byte by byte from one task that always raises rx_last on the final valid byte. It performs host accesses one at a time from separate tasks. It never reads a data word in the cycle that the same word is written.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int unsigned CTRL_FULL_BIT = 0;
  localparam int unsigned CTRL_IRQ_BIT  = 3;
  localparam int unsigned DEST_BYTES    = 6;

  typedef enum logic [1:0] {
    HSEL_NONE = 2'd0,
    HSEL_DATA = 2'd1,
    HSEL_CTRL = 2'd2
  } host_sel_e;
endpackage

// File: rtl/rxpp_dest_filter.sv
module rxpp_dest_filter
  import rxpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_en,
  input  logic [2:0]  pos,
  input  logic [7:0]  byte_in,
  input  logic [47:0] station,
  output logic        decide,
  output logic        pass
);
  logic [7:0] st_byte [DEST_BYTES];
  generate
    for (genvar k = 0; k < DEST_BYTES; k++) begin : g_st
      assign st_byte[k] = station[8*k +: 8];
    end
  endgenerate

  logic       grp_q, eq_q;
  logic       grp_now, eq_now, hit, in_dest;
  logic [2:0] sel;

  always_comb begin
    in_dest = (pos < 3'(DEST_BYTES));
    sel     = in_dest ? pos : 3'd0;
    hit     = in_dest && (byte_in == st_byte[sel]);
    grp_now = (pos == 3'd0) ? byte_in[0] : grp_q;
    eq_now  = ((pos == 3'd0) ? 1'b1 : eq_q) && hit;
    decide  = byte_en && (pos == 3'(DEST_BYTES - 1));
    pass    = grp_now || eq_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= 1'b0;
      eq_q  <= 1'b0;
    end else if (byte_en && in_dest) begin
      grp_q <= grp_now;
      eq_q  <= eq_now;
    end
  end
endmodule

// File: rtl/rxpp_word_packer.sv
module rxpp_word_packer (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_en,
  input  logic        byte_last,
  input  logic [1:0]  lane,
  input  logic [7:0]  byte_in,
  output logic        word_done,
  output logic [31:0] word_out
);
  logic [31:0] acc_q;

  always_comb begin
    word_out  = acc_q | ({24'd0, byte_in} << {lane, 3'b000});
    word_done = byte_en && ((lane == 2'd3) || byte_last);
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (byte_en) acc_q <= word_done ? '0 : word_out;
  end
endmodule

// File: rtl/rxpp_buf_ram.sv
module rxpp_buf_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxpp_rx_buffers.sv
module rxpp_rx_buffers
  import rxpp_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned LOST_W    = 8,
  localparam int unsigned ADDR_W   = $clog2(2 * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [47:0]       station_mac,
  input  logic              pingpong_en,
  input  logic              irq_global_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  input  logic              host_rd,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              rx_irq,
  output logic [LOST_W-1:0] lost_frames
);
  localparam int unsigned WORDS      = BUF_BYTES / 4;
  localparam int unsigned WIDX_W     = $clog2(WORDS);
  localparam int unsigned MAW        = WIDX_W + 1;
  localparam int unsigned DATA_BYTES = BUF_BYTES - 4;
  localparam int unsigned CNT_W      = WIDX_W + 3;
  localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(WORDS - 1);

  // frame tracking
  logic [CNT_W-1:0] cnt_q;
  logic tgt_q, drop_q, accepted_q, ovf_q, act_buf_q;
  logic [31:0] ctrl_q [2];
  logic first, cur_tgt, tgt, drop, ovf_now, accept_now, live, stored, lost_ev;
  logic [2:0] pos;
  logic [WIDX_W-1:0] widx;
  logic decide, pass, pk_done;
  logic [31:0] pk_word, hold_q;

  always_comb begin
    first      = (cnt_q == '0);
    cur_tgt    = act_buf_q & pingpong_en;
    tgt        = first ? cur_tgt : tgt_q;
    drop       = first ? ctrl_q[cur_tgt][CTRL_FULL_BIT] : drop_q;
    pos        = (cnt_q < CNT_W'(DEST_BYTES)) ? cnt_q[2:0] : 3'(DEST_BYTES);
    widx       = cnt_q[WIDX_W+1:2];
    ovf_now    = ovf_q || (cnt_q >= CNT_W'(DATA_BYTES));
    accept_now = accepted_q || (decide && pass);
    live       = !drop && !ovf_now && accept_now;
    stored     = rx_valid && rx_last && live;
    lost_ev    = rx_valid && rx_last && drop && accept_now;
  end

  rxpp_dest_filter u_filter (
    .clk(clk), .rst(rst), .byte_en(rx_valid), .pos(pos), .byte_in(rx_data),
    .station(station_mac), .decide(decide), .pass(pass)
  );

  rxpp_word_packer u_packer (
    .clk(clk), .rst(rst), .byte_en(rx_valid), .byte_last(rx_last),
    .lane(cnt_q[1:0]), .byte_in(rx_data), .word_done(pk_done), .word_out(pk_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      tgt_q      <= 1'b0;
      drop_q     <= 1'b0;
      accepted_q <= 1'b0;
      ovf_q      <= 1'b0;
      hold_q     <= '0;
    end else if (rx_valid) begin
      if (first) begin
        tgt_q  <= cur_tgt;
        drop_q <= drop;
      end
      if (pk_done && (widx == '0)) hold_q <= pk_word;
      if (rx_last) begin
        cnt_q      <= '0;
        accepted_q <= 1'b0;
        ovf_q      <= 1'b0;
      end else begin
        if (cnt_q != CNT_W'(BUF_BYTES)) cnt_q <= cnt_q + 1'b1;
        accepted_q <= accept_now;
        ovf_q      <= ovf_now;
      end
    end
  end

  // write port: word 0 is held until the filter decides
  logic            pend_v_q;
  logic [MAW-1:0]  pend_addr_q;
  logic [31:0]     pend_data_q;
  logic            w_en;
  logic [MAW-1:0]  w_addr;
  logic [31:0]     w_data;
  logic            open_now;

  always_comb begin
    open_now = decide && pass && !drop;
    w_en     = 1'b0;
    w_addr   = '0;
    w_data   = '0;
    if (pend_v_q) begin
      w_en   = 1'b1;
      w_addr = pend_addr_q;
      w_data = pend_data_q;
    end else if (open_now) begin
      w_en   = 1'b1;
      w_addr = {tgt, {WIDX_W{1'b0}}};
      w_data = hold_q;
    end else if (pk_done && live && (widx != '0)) begin
      w_en   = 1'b1;
      w_addr = {tgt, widx};
      w_data = pk_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_v_q <= open_now && pk_done;
      if (open_now && pk_done) begin
        pend_addr_q <= {tgt, widx};
        pend_data_q <= pk_word;
      end
    end
  end

  // host decode
  logic              h_buf, h_ctrl;
  logic [WIDX_W-1:0] h_widx;
  logic [31:0]       ram_rdata, ctrl_rd_q;
  host_sel_e         sel_q;

  always_comb begin
    h_buf  = host_addr[ADDR_W-1];
    h_widx = host_addr[ADDR_W-2:2];
    h_ctrl = (h_widx == CTRL_IDX);
  end

  rxpp_buf_ram #(.DEPTH(2 * WORDS), .AW(MAW)) u_ram (
    .clk(clk), .we(w_en), .waddr(w_addr), .wdata(w_data),
    .re(host_rd && !h_ctrl), .raddr({h_buf, h_widx}), .rdata(ram_rdata)
  );

  generate
    for (genvar b = 0; b < 2; b++) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst) begin
          ctrl_q[b] <= '0;
        end else begin
          if (host_wr && h_ctrl && (h_buf == 1'(b))) ctrl_q[b] <= host_wdata;
          if (stored && (tgt == 1'(b))) ctrl_q[b][CTRL_FULL_BIT] <= 1'b1;
        end
      end
    end
  endgenerate

  logic              irq_q;
  logic [LOST_W-1:0] lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_buf_q <= 1'b0;
      irq_q     <= 1'b0;
      lost_q    <= '0;
      sel_q     <= HSEL_NONE;
      ctrl_rd_q <= '0;
    end else begin
      if (stored && pingpong_en) act_buf_q <= ~cur_tgt;
      irq_q <= stored && ctrl_q[0][CTRL_IRQ_BIT] && irq_global_en;
      if (lost_ev && !(&lost_q)) lost_q <= lost_q + 1'b1;
      sel_q <= !host_rd ? HSEL_NONE : (h_ctrl ? HSEL_CTRL : HSEL_DATA);
      if (host_rd) ctrl_rd_q <= ctrl_q[h_buf];
    end
  end

  always_comb begin
    case (sel_q)
      HSEL_DATA: host_rdata = ram_rdata;
      HSEL_CTRL: host_rdata = ctrl_rd_q;
      default:   host_rdata = '0;
    endcase
  end

  assign host_rvalid = (sel_q != HSEL_NONE);
  assign rx_irq      = irq_q;
  assign lost_frames = lost_q;
endmodule

// File: rtl/rxpp_rx_buffers_chk.sv
module rxpp_rx_buffers_chk #(
  parameter int unsigned LOST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              irq_global_en,
  input logic              host_rd,
  input logic              host_rvalid,
  input logic              rx_irq,
  input logic [LOST_W-1:0] lost_frames
);
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(irq_global_en));

  a_r6_irq_after_last: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_valid && rx_last));

  a_r11_rvalid_after_rd: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);

  a_r11_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);

  a_r3_lost_step: assert property (@(posedge clk) disable iff (rst)
    (lost_frames != $past(lost_frames)) |->
      ($past(rx_valid && rx_last) && (lost_frames == $past(lost_frames) + 1'b1)));
endmodule

bind rxpp_rx_buffers rxpp_rx_buffers_chk #(.LOST_W(LOST_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last),
  .irq_global_en(irq_global_en), .host_rd(host_rd), .host_rvalid(host_rvalid),
  .rx_irq(rx_irq), .lost_frames(lost_frames)
);

// File: tb/rxpp_rx_buffers_tb.sv
module rxpp_rx_buffers_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 64;
  localparam int LOST_W     = 4;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = (BUF_BYTES - 4) / 4;
  localparam int DATA_B     = BUF_BYTES - 4;
  localparam logic [ADDR_W-1:0] CTRL0 = 7'h3C;
  localparam logic [ADDR_W-1:0] CTRL1 = 7'h7C;
  localparam logic [47:0] MAC = 48'h56_34_12_EF_CD_02;

  logic clk = 0, rst = 1;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, rx_last = 0, pingpong_en = 1, irq_global_en = 1;
  logic [ADDR_W-1:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_rvalid, rx_irq;
  logic [LOST_W-1:0] lost_frames;

  rxpp_rx_buffers #(.BUF_BYTES(BUF_BYTES), .LOST_W(LOST_W)) u_dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .station_mac(MAC), .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .rx_irq(rx_irq),
    .lost_frames(lost_frames)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  logic [7:0]  fb [128];
  logic [31:0] exp_mem [2*DATA_W];
  logic        known [2*DATA_W];
  logic [31:0] rd;
  int exp_tgt = 0;
  int exp_lost = 0;

  always @(negedge clk) if (rx_irq) irq_cnt++;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input int len, input int kind, input int seed);
    for (int n = 0; n < len; n++) fb[n] = 8'(n * 7 + seed * 13 + 5);
    if (kind != 1) for (int k = 0; k < 6; k++) fb[k] = MAC[8*k +: 8];
    if (kind == 1) fb[0] = 8'h31;
    if (kind == 2) fb[5] = fb[5] ^ 8'h01;
  endtask

  task automatic send(input int len);
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fb[n]; rx_last = (n == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic apply(input int b, input int len);
    int lim;
    lim = (len < DATA_B) ? len : DATA_B;
    for (int w = 0; w < DATA_W; w++) begin
      if (4 * w < lim) begin
        logic [31:0] v;
        v = 0;
        for (int l = 0; l < 4; l++) if (4 * w + l < lim) v[8*l +: 8] = fb[4*w+l];
        exp_mem[b*DATA_W+w] = v;
        known[b*DATA_W+w] = 1;
      end
    end
  endtask

  task automatic hread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_rd = 1;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic hwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic check_buf(input int b, input string req);
    for (int w = 0; w < DATA_W; w++) if (known[b*DATA_W+w]) begin
      hread(ADDR_W'(b * BUF_BYTES + 4 * w), rd);
      check(rd === exp_mem[b*DATA_W+w], req, rd, exp_mem[b*DATA_W+w]);
    end
  endtask

  task automatic check_ctrl(input int b, input logic [31:0] exp, input string req);
    hread(b ? CTRL1 : CTRL0, rd);
    check(rd === exp, req, rd, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ic;
    for (int i = 0; i < 2*DATA_W; i++) begin known[i] = 0; exp_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    check(rx_irq === 0 && host_rvalid === 0, "R8 irq/rvalid after reset", {rx_irq, host_rvalid}, 0);
    check(lost_frames === 0, "R8 lost after reset", 32'(lost_frames), 0);
    check_ctrl(0, 0, "R8 ctrl0 reset");
    check_ctrl(1, 0, "R8 ctrl1 reset");
    // R11 rvalid timing
    @(negedge clk); host_addr = CTRL0; host_rd = 1;
    @(negedge clk); host_rd = 0;
    check(host_rvalid === 1, "R11 rvalid after rd", 32'(host_rvalid), 1);
    @(negedge clk);
    check(host_rvalid === 0, "R11 rvalid one cycle", 32'(host_rvalid), 0);

    // R9 control write stored as written
    hwrite(CTRL0, 32'hA5A5_0008);
    check_ctrl(0, 32'hA5A5_0008, "R9 ctrl0 written");
    hwrite(CTRL0, 32'h8);

    // unicast match into buffer 0: R4 R5 R6
    ic = irq_cnt;
    build(13, 0, 1); send(13); apply(0, 13);
    check_ctrl(0, 32'h9, "R5 ctrl0 full set");
    check(irq_cnt == ic + 1, "R6 irq on store", irq_cnt, ic + 1);
    check_buf(0, "R4 buf0 packing");

    // group frame into buffer 1: R2 R7 R6
    ic = irq_cnt;
    build(20, 1, 2); send(20); apply(1, 20);
    check_ctrl(1, 32'h1, "R7 second frame to buffer 1");
    check(irq_cnt == ic + 1, "R6 irq from buffer 1 uses ctrl0 enable", irq_cnt, ic + 1);
    check_buf(1, "R2 group frame stored");

    // buffer 0 full: drop, R3
    build(16, 0, 3); send(16);
    check(lost_frames === 1, "R3 lost counted", 32'(lost_frames), 1);
    check_ctrl(0, 32'h9, "R3 ctrl0 unchanged");
    check_buf(0, "R3 buf0 unchanged on drop");
    build(16, 2, 4); send(16);
    check(lost_frames === 1, "R2 filtered frame not lost", 32'(lost_frames), 1);

    // free buffer 0, reject cases: R9 R2
    hwrite(CTRL0, 32'h8);
    build(12, 2, 5); send(12);
    check_ctrl(0, 32'h8, "R2 mismatch rejected");
    check_buf(0, "R2 buf0 unchanged after reject");
    build(5, 0, 6); send(5);
    check_ctrl(0, 32'h8, "R2 short frame rejected");
    check_buf(0, "R2 buf0 unchanged after short frame");

    // exact data area length
    build(DATA_B, 0, 7); send(DATA_B); apply(0, DATA_B);
    check_ctrl(0, 32'h9, "R10 full-length frame stored");
    check_buf(0, "R4 full-length packing");

    // oversize to buffer 1: R10
    hwrite(CTRL1, 0);
    ic = irq_cnt;
    build(DATA_B + 1, 0, 8); send(DATA_B + 1); apply(1, DATA_B + 1);
    check_ctrl(1, 0, "R10 oversize not marked");
    check(irq_cnt == ic, "R10 no irq on oversize", irq_cnt, ic);
    check(lost_frames === 1, "R10 oversize not lost", 32'(lost_frames), 1);
    check_buf(1, "R10 truncated contents");
    build(8, 0, 9); send(8); apply(1, 8);
    check_ctrl(1, 32'h1, "R10 target unchanged by oversize");
    check_buf(1, "R4 short frame packing");

    // global enable off: R6
    hwrite(CTRL0, 32'h8);
    irq_global_en = 0;
    ic = irq_cnt;
    build(10, 0, 10); send(10); apply(0, 10);
    check_ctrl(0, 32'h9, "R5 stored with gie off");
    check(irq_cnt == ic, "R6 no irq with gie off", irq_cnt, ic);
    irq_global_en = 1;

    // ctrl0 I clear, frame to buffer 1: R6
    hwrite(CTRL0, 0);
    hwrite(CTRL1, 0);
    ic = irq_cnt;
    build(11, 0, 11); send(11); apply(1, 11);
    check_ctrl(1, 32'h1, "R7 alternation to buffer 1");
    check(irq_cnt == ic, "R6 no irq with ctrl0 bit3 clear", irq_cnt, ic);

    // ping-pong off: R7
    pingpong_en = 0;
    hwrite(CTRL0, 32'h8);
    hwrite(CTRL1, 0);
    build(7, 0, 12); send(7); apply(0, 7);
    check_ctrl(0, 32'h9, "R7 no pingpong frame A buffer 0");
    hwrite(CTRL0, 32'h8);
    build(9, 0, 13); send(9); apply(0, 9);
    check_ctrl(0, 32'h9, "R7 no pingpong frame B buffer 0");
    check_ctrl(1, 32'h0, "R7 buffer 1 untouched");
    check_buf(0, "R7 buffer 0 data");

    // data words read-only: R1
    hwrite(7'h00, 32'hDEAD_BEEF);
    hwrite(7'h44, 32'h1234_5678);
    check_buf(0, "R1 data write ignored buf0");
    check_buf(1, "R1 data write ignored buf1");

    // sweep of lengths with ping-pong: R4 R5 R7
    pingpong_en = 1;
    hwrite(CTRL0, 32'h8);
    exp_tgt = 0;
    for (int len = 6; len <= DATA_B; len++) begin
      ic = irq_cnt;
      build(len, (len % 3 == 0) ? 1 : 0, len);
      send(len); apply(exp_tgt, len);
      check_ctrl(exp_tgt, exp_tgt ? 32'h1 : 32'h9, "R7 sweep target full");
      check(irq_cnt == ic + 1, "R6 sweep irq", irq_cnt, ic + 1);
      check_buf(exp_tgt, "R4 sweep packing");
      hwrite(exp_tgt ? CTRL1 : CTRL0, exp_tgt ? 32'h0 : 32'h8);
      exp_tgt ^= 1;
    end
    check(lost_frames === 4'(exp_lost + 1), "R3 lost stable", 32'(lost_frames), exp_lost + 1);
    finish_run();
  end
endmodule